// File: doc/BRIEF.md
# Input Delay Eye-Centering Calibrator

This block trains a programmable input delay line so that one sample per bit lands in the middle of the data eye. Both ends are assumed to run from phase-coherent clocks, and the far end is assumed to send a PRBS7 training sequence (x^7 + x^6 + 1) while calibration runs. After a start pulse, the block steps the tap code from 0 up to the highest code. At each tap it lets the line settle, seeds a self-synchronizing pattern checker from the incoming bits, and counts mismatches over a fixed window. It then classifies the tap as an edge tap (count above a threshold), a clean tap (count zero), or neither.

Once the whole range has been swept, the block applies a final tap. If two separate edge regions were seen, the final tap lies midway between the last tap of the first region and the first tap of the second. If fewer than two were seen, the final tap is the centre of the widest run of clean taps. If no tap was clean, the block reports failure. No tracking happens after calibration. A new start pulse repeats the whole procedure.

The controller is a single state machine. Its states are IDLE, SETTLE, SEED, MEASURE, CLASSIFY, DECIDE, DONE and FAIL. The transitions are as follows:
- A start pulse in any state moves to SETTLE with the tap at 0.
- SETTLE moves to SEED after SETTLE_LEN cycles.
- SEED moves to MEASURE after 7 cycles.
- MEASURE moves to CLASSIFY after WINDOW_LEN cycles.
- CLASSIFY moves back to SETTLE with the tap increased by one. At the highest tap it moves to DECIDE instead.
- DECIDE moves to DONE, or to FAIL when no clean tap was found.
- DONE and FAIL hold until the next start.

Top module: `eye_cal_top`

## Requirements
- R1: After reset, tap_o is 0, and done_o and fail_o are both 0.
- R2: A start pulse begins a sweep at tap 0. The tap then rises by exactly one every DWELL = SETTLE_LEN + 7 + WINDOW_LEN + 1 cycles, up to 2^TAP_W - 1.
- R3: At each tap, the error count is the number of the WINDOW_LEN compared bits whose value differs from the XOR of the bits received 6 and 7 bit times earlier. The seven bits received before the window seed the checker. A bit-inverted PRBS7 stream therefore counts WINDOW_LEN errors, and a clean stream counts zero.
- R4: A tap is an edge tap when its error count is strictly greater than the threshold. The threshold is thresh_i, except that a thresh_i of 0 selects DEF_THRESH (default 64).
- R5: A tap is clean only when its error count is zero. A tap with a nonzero count at or below the threshold is neither clean nor an edge tap.
- R6: When two or more separate edge regions are found, the final tap is floor((last tap of first region + first tap of second region) / 2). Any later regions are ignored.
- R7: When fewer than two edge regions are found, the final tap is start + floor((length - 1) / 2) of the longest run of consecutive clean taps. When runs tie in length, the lowest one wins.
- R8: When no tap is clean, fail_o rises, done_o stays 0 and tap_o is 0. done_o and fail_o are never high together.
- R9: done_o or fail_o rises exactly 2^TAP_W * DWELL + 1 cycles after the clock edge that samples start_i. After that, tap_o holds steady until the next start.
- R10: A start pulse at any time, including during a sweep or after completion, clears done_o and fail_o and sets tap_o to 0 on the next edge. It then restarts the full sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one received bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins or restarts calibration |
| thresh_i | input | THR_W | Edge threshold on the error count; 0 selects DEF_THRESH |
| rx_bit_i | input | 1 | Received bit sampled through the delay line |
| tap_o | output | TAP_W | Delay tap code driven to the delay line |
| done_o | output | 1 | High when the final tap has been applied |
| fail_o | output | 1 | High when no clean tap was found |

## Verification
The only result that arrives late is the completion flag. It rises exactly 2^TAP_W * DWELL + 1 cycles after the start edge. The bench counts rising edges from that edge and expects the flag to be visible at the falling edge after edge number 2^TAP_W * DWELL + 2, where it then reads the final tap. The start-clearing effect is due one edge after start, and the bench checks it at the following falling edge. Tap stepping is checked at a fixed edge count inside a sweep, using floor((edges - 1) / DWELL). The bench builds its stimulus from a channel model: every tap inside a declared noisy region receives either a fully inverted PRBS7 stream or one with one bit in eight flipped. The expected final taps are worked out from the R6 and R7 rules.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;

    localparam int SEED_LEN = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEED,
        ST_MEASURE,
        ST_CLASSIFY,
        ST_DECIDE,
        ST_DONE,
        ST_FAIL
    } cal_state_e;

endpackage

// File: rtl/eye_cal_prbs_chk.sv
module eye_cal_prbs_chk #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          cmp_en,
    input  logic          rx_bit,
    output logic [CW-1:0] err_cnt
);
    // hist[0] is the most recent bit; hist[k] arrived k+1 bit times ago
    logic [6:0] hist;
    logic       predicted;

    assign predicted = hist[5] ^ hist[6];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[5:0], rx_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_cnt <= '0;
        end else if (cmp_en && (rx_bit != predicted)) begin
            err_cnt <= err_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/eye_cal_track.sv
module eye_cal_track #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic [TAP_W-1:0] tap,
    input  logic             is_edge,
    input  logic             is_clean,
    output logic             two_edges,
    output logic [TAP_W-1:0] e1_end,
    output logic [TAP_W-1:0] e2_start,
    output logic [TAP_W-1:0] best_start,
    output logic [TAP_W:0]   best_len
);
    localparam int LW = TAP_W + 1;

    logic [1:0]       n_regions;
    logic             prev_edge;
    logic [TAP_W-1:0] run_start;
    logic [LW-1:0]    run_len;
    logic [LW-1:0]    next_len;
    logic [TAP_W-1:0] next_start;

    assign two_edges  = (n_regions == 2'd2);
    assign next_len   = run_len + LW'(1);
    assign next_start = (run_len == '0) ? tap : run_start;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            n_regions  <= '0;
            prev_edge  <= 1'b0;
            e1_end     <= '0;
            e2_start   <= '0;
            run_start  <= '0;
            run_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (upd) begin
            // edge-region bookkeeping: first region end, second region start
            if (is_edge) begin
                if (!prev_edge) begin
                    if (n_regions == 2'd0) begin
                        n_regions <= 2'd1;
                        e1_end    <= tap;
                    end else if (n_regions == 2'd1) begin
                        n_regions <= 2'd2;
                        e2_start  <= tap;
                    end
                end else if (n_regions == 2'd1) begin
                    e1_end <= tap;
                end
                prev_edge <= 1'b1;
            end else begin
                prev_edge <= 1'b0;
            end
            // widest clean run; strict compare keeps the lowest on ties
            if (is_clean) begin
                run_len   <= next_len;
                run_start <= next_start;
                if (next_len > best_len) begin
                    best_len   <= next_len;
                    best_start <= next_start;
                end
            end else begin
                run_len <= '0;
            end
        end
    end
endmodule

// File: rtl/eye_cal_pick.sv
module eye_cal_pick #(
    parameter int TAP_W = 7
) (
    input  logic             two_edges,
    input  logic [TAP_W-1:0] e1_end,
    input  logic [TAP_W-1:0] e2_start,
    input  logic [TAP_W-1:0] best_start,
    input  logic [TAP_W:0]   best_len,
    output logic             pick_fail,
    output logic [TAP_W-1:0] pick_tap
);
    logic [TAP_W:0]   edge_sum;
    logic [TAP_W:0]   half_len;
    logic [TAP_W-1:0] clean_mid;

    assign edge_sum  = {1'b0, e1_end} + {1'b0, e2_start};
    assign half_len  = (best_len - (TAP_W+1)'(1)) >> 1;
    assign clean_mid = best_start + half_len[TAP_W-1:0];
    assign pick_fail = (best_len == '0);

    always_comb begin
        if (pick_fail) begin
            pick_tap = '0;
        end else if (two_edges) begin
            pick_tap = edge_sum[TAP_W:1];
        end else begin
            pick_tap = clean_mid;
        end
    end
endmodule

// File: rtl/eye_cal_top.sv
module eye_cal_top
    import eye_cal_pkg::*;
#(
    parameter int TAP_W      = 7,
    parameter int SETTLE_LEN = 16,
    parameter int WINDOW_LEN = 1024,
    parameter int THR_W      = 11,
    parameter int DEF_THRESH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [THR_W-1:0] thresh_i,
    input  logic             rx_bit_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam int TAP_MAX = (1 << TAP_W) - 1;
    localparam int CW      = $clog2(WINDOW_LEN + 1);
    localparam int PH_MAX  = (WINDOW_LEN > SETTLE_LEN) ? WINDOW_LEN : SETTLE_LEN;
    localparam int PH_W    = $clog2(PH_MAX + SEED_LEN + 1);

    cal_state_e       state, state_nx;
    logic [PH_W-1:0]  phase;
    logic [CW-1:0]    err_cnt;
    logic [THR_W-1:0] eff_thr;
    logic             is_edge, is_clean;
    logic             two_edges, pick_fail;
    logic [TAP_W-1:0] e1_end, e2_start, best_start, pick_tap;
    logic [TAP_W:0]   best_len;
    logic             last_settle, last_seed, last_win, at_top;

    assign last_settle = (phase == PH_W'(SETTLE_LEN - 1));
    assign last_seed   = (phase == PH_W'(SEED_LEN - 1));
    assign last_win    = (phase == PH_W'(WINDOW_LEN - 1));
    assign at_top      = (tap_o == TAP_W'(TAP_MAX));

    assign eff_thr  = (thresh_i == '0) ? THR_W'(DEF_THRESH) : thresh_i;
    assign is_edge  = (32'(err_cnt) > 32'(eff_thr));
    assign is_clean = (err_cnt == '0);

    eye_cal_prbs_chk #(.CW(CW)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_SETTLE),
        .shift_en ((state == ST_SEED) || (state == ST_MEASURE)),
        .cmp_en   (state == ST_MEASURE),
        .rx_bit   (rx_bit_i),
        .err_cnt  (err_cnt)
    );

    eye_cal_track #(.TAP_W(TAP_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_i),
        .upd        (state == ST_CLASSIFY),
        .tap        (tap_o),
        .is_edge    (is_edge),
        .is_clean   (is_clean),
        .two_edges  (two_edges),
        .e1_end     (e1_end),
        .e2_start   (e2_start),
        .best_start (best_start),
        .best_len   (best_len)
    );

    eye_cal_pick #(.TAP_W(TAP_W)) u_pick (
        .two_edges  (two_edges),
        .e1_end     (e1_end),
        .e2_start   (e2_start),
        .best_start (best_start),
        .best_len   (best_len),
        .pick_fail  (pick_fail),
        .pick_tap   (pick_tap)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (start_i) begin
            state_nx = ST_SETTLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_SETTLE:   if (last_settle) state_nx = ST_SEED;
                ST_SEED:     if (last_seed)   state_nx = ST_MEASURE;
                ST_MEASURE:  if (last_win)    state_nx = ST_CLASSIFY;
                ST_CLASSIFY: state_nx = at_top ? ST_DECIDE : ST_SETTLE;
                ST_DECIDE:   state_nx = pick_fail ? ST_FAIL : ST_DONE;
                ST_DONE:     state_nx = ST_DONE;
                ST_FAIL:     state_nx = ST_FAIL;
            endcase
        end
    end

    // dwell phase counter
    always_ff @(posedge clk) begin
        if (!rst_n || start_i || (state_nx != state)) begin
            phase <= '0;
        end else if ((state == ST_SETTLE) || (state == ST_SEED) || (state == ST_MEASURE)) begin
            phase <= phase + PH_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            tap_o  <= '0;
            done_o <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            unique case (state)
                ST_CLASSIFY: if (!at_top) tap_o <= tap_o + TAP_W'(1);
                ST_DECIDE: begin
                    tap_o  <= pick_tap;
                    done_o <= !pick_fail;
                    fail_o <= pick_fail;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eye_cal_sva.sv
module eye_cal_sva #(
    parameter int TAP_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [TAP_W-1:0] tap_o,
    input logic             done_o,
    input logic             fail_o
);
    p_tap_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !done_o && !fail_o) |=>
        ((tap_o == $past(tap_o)) || (tap_o == $past(tap_o) + 1'b1) || done_o || fail_o));

    p_fail_tap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (tap_o == '0));

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_hold_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(tap_o)));

    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !fail_o && (tap_o == '0)));
endmodule

bind eye_cal_top eye_cal_sva #(.TAP_W(TAP_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tap_o   (tap_o),
    .done_o  (done_o),
    .fail_o  (fail_o)
);

// File: tb/sim_eye_cal_top.sv
module sim_eye_cal_top;
    localparam int TW    = 6;
    localparam int WIN   = 128;
    localparam int SET   = 16;
    localparam int THW   = 11;
    localparam int DWELL = SET + 7 + WIN + 1;
    localparam int NTAP  = 1 << TW;
    localparam int LAT   = NTAP * DWELL + 2;

    typedef struct packed {
        logic [7:0]  a_lo, a_hi, b_lo, b_hi, c_lo, c_hi;
        logic        sparse;
        logic [10:0] thr;
        logic [7:0]  exp_tap;
        logic        exp_fail;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'd5,   8'd8,  8'd30,  8'd34, 8'd255, 8'd0,  1'b0, 11'd20,  8'd19, 1'b0}, // R6
        '{8'd0,   8'd2,  8'd20,  8'd23, 8'd255, 8'd0,  1'b0, 11'd20,  8'd11, 1'b0}, // R6
        '{8'd40,  8'd45, 8'd55,  8'd63, 8'd255, 8'd0,  1'b0, 11'd20,  8'd50, 1'b0}, // R6
        '{8'd3,   8'd4,  8'd25,  8'd27, 8'd50,  8'd52, 1'b0, 11'd20,  8'd14, 1'b0}, // R6
        '{8'd20,  8'd25, 8'd255, 8'd0,  8'd255, 8'd0,  1'b0, 11'd20,  8'd44, 1'b0}, // R7
        '{8'd255, 8'd0,  8'd255, 8'd0,  8'd255, 8'd0,  1'b0, 11'd20,  8'd31, 1'b0}, // R7
        '{8'd5,   8'd8,  8'd30,  8'd34, 8'd255, 8'd0,  1'b1, 11'd20,  8'd19, 1'b0}, // R4
        '{8'd5,   8'd8,  8'd30,  8'd34, 8'd255, 8'd0,  1'b1, 11'd0,   8'd49, 1'b0}, // R4 R5
        '{8'd0,   8'd63, 8'd255, 8'd0,  8'd255, 8'd0,  1'b0, 11'd20,  8'd0,  1'b1}, // R8
        '{8'd31,  8'd32, 8'd255, 8'd0,  8'd255, 8'd0,  1'b0, 11'd20,  8'd15, 1'b0}, // R7
        '{8'd5,   8'd8,  8'd30,  8'd34, 8'd255, 8'd0,  1'b0, 11'd128, 8'd49, 1'b0}, // R3 R4
        '{8'd5,   8'd8,  8'd30,  8'd34, 8'd255, 8'd0,  1'b0, 11'd127, 8'd19, 1'b0}  // R3 R4
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start_i;
    logic [THW-1:0] thr;
    logic           rx_bit;
    logic [TW-1:0]  tap_o;
    logic           done_o, fail_o;

    always #4 clk = ~clk;

    eye_cal_top #(
        .TAP_W(TW), .SETTLE_LEN(SET), .WINDOW_LEN(WIN), .THR_W(THW), .DEF_THRESH(64)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .thresh_i(thr),
        .rx_bit_i(rx_bit), .tap_o(tap_o), .done_o(done_o), .fail_o(fail_o)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    vec_t        cur = VECS[0];
    logic [6:0]  lfsr = 7'h5A;
    logic [31:0] bitcnt = '0;

    function automatic logic in_rng(input logic [7:0] t, input logic [7:0] lo, input logic [7:0] hi);
        return (t >= lo) && (t <= hi);
    endfunction

    function automatic logic noisy(input logic [7:0] t);
        return in_rng(t, cur.a_lo, cur.a_hi) || in_rng(t, cur.b_lo, cur.b_hi) ||
               in_rng(t, cur.c_lo, cur.c_hi);
    endfunction

    function automatic string vec_tag(input int i);
        case (i)
            4, 5, 9: return "R7";
            6:       return "R4";
            7:       return "R5";
            8:       return "R8";
            10, 11:  return "R3";
            default: return "R6";
        endcase
    endfunction

    // channel model: PRBS7 source, corrupted at taps inside noisy regions
    always @(negedge clk) begin
        lfsr   <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        bitcnt <= bitcnt + 1;
        rx_bit <= lfsr[6] ^ (noisy({2'b00, tap_o}) & (cur.sparse ? (bitcnt[2:0] == 3'd0) : 1'b1));
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        int c;
        cur = VECS[i];
        thr = cur.thr;
        @(negedge clk) start_i = 1'b1;
        @(posedge clk) c = 1;
        @(negedge clk) start_i = 1'b0;
        check(!done_o && !fail_o && tap_o == '0, "R10 start clears outputs",
              int'({done_o, fail_o, tap_o}), 0);
        while (!(done_o || fail_o) && c < LAT + 100) begin
            @(posedge clk) c++;
            @(negedge clk);
        end
        check(c == LAT, "R9 completion latency", c, LAT);
        check(fail_o == cur.exp_fail && done_o == !cur.exp_fail,
              {vec_tag(i), " done/fail flags"}, int'({done_o, fail_o}), int'({!cur.exp_fail, cur.exp_fail}));
        check({2'b00, tap_o} == cur.exp_tap, {vec_tag(i), " final tap"}, int'(tap_o), int'(cur.exp_tap));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        rst_n   = 1'b0;
        start_i = 1'b0;
        thr     = 11'd20;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tap_o == '0, "R1 tap after reset", int'(tap_o), 0);
        check(!done_o, "R1 done after reset", int'(done_o), 0);
        check(!fail_o, "R1 fail after reset", int'(fail_o), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R2 tap progression and R10 restart in the middle of a sweep
        cur = VECS[0];
        thr = cur.thr;
        @(negedge clk) start_i = 1'b1;
        @(posedge clk) c = 1;
        @(negedge clk) start_i = 1'b0;
        check(!done_o && tap_o == '0, "R10 start after done clears", int'({done_o, tap_o}), 0);
        while (c < 1000) begin
            @(posedge clk) c++;
        end
        @(negedge clk);
        check(int'(tap_o) == (1000 - 1) / DWELL, "R2 tap during sweep", int'(tap_o), (1000 - 1) / DWELL);
        run_vec(0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule